// File: doc/BRIEF.md
# Host Bridge Configuration Register Bank

This block holds the configuration dwords that a host bridge answers for above its generic header. A requester presents one request at a time on a valid/ready interface: a byte offset that is dword aligned, a read or write flag, and write data. The block answers one cycle after it accepts the request, with read data and an invalid-register error flag. Offsets below 0x40 belong to a generic header that lives elsewhere. They are passed through a combinational side port, and its data and error are returned in the same way. The one exception is a read of the status/command dword at 0x04, which the block answers itself.

Above 0x40 the block keeps two DRAM row dwords, two scratch dwords, a pair of memory-attribute dwords and a lockable system-management word. Some offsets return fixed constants, some read as zero and drop writes, and every other offset is refused. A write to an attribute dword is offered to an external attribute decoder as the complete new 64-bit pair. The request is held until that decoder acknowledges it. Accepted writes to the system-management word are cleaned by a fixed mask chain. Once the word's lock bit is set, later writes are dropped. A sticky flag records that software tried to set bits that the block never stores.

Top module: `hbcfg_regbank`

## Requirements
- R1: A read of offset 0x04 returns 0x02000006 with no error and does not select the header port. A write to 0x04 is routed to the header port.
- R2: Every other access below 0x40 raises `hdr_sel` with `hdr_write` equal to the request direction in the request cycle. A read returns `hdr_rdata`, and reads and writes both return `hdr_err` as the error.
- R3: After reset, 0x60 reads 0x02020202, 0x64 reads 0x00000002, 0xD0 and 0xD4 read 0, 0x58 reads 0x00000003, 0x5C reads 0, 0x70 reads 0x38020000, `smm_flag` is 0 and `rsp_valid` is 0.
- R4: A write to 0x60, 0x64, 0xD0 or 0xD4 stores the full 32-bit value, and a later read returns it.
- R5: A read of 0x70 returns ((word AND 0xC77C) OR 0x3802) in bits 31:16 and zero in bits 15:0.
- R6: An accepted write to 0x70 stores the upper 16 bits of the write data after the following steps, in order: clear 0x8700, AND with 0xC77C, OR with 0x3802, clear 0x4000 and clear 0x0040. The result equals (data[31:16] AND 0x003C) OR 0x3802.
- R7: While bit 4 of the stored system-management word is 1, writes to 0x70 leave the word unchanged and still complete without error.
- R8: 0x78 reads 0x380A0000 and accepts writes with no effect. 0xF8 reads 0x00000F20, and a write to 0xF8 returns an error.
- R9: 0x50, 0x54, 0x68, 0x74, 0xF0 and 0xF4 read as 0 without error, and writes to them change nothing.
- R10: Any offset at or above 0x40 not named in R3 to R9 returns the error flag with zero data, for both reads and writes.
- R11: A write to 0x58 or 0x5C holds `req_ready` low and drives `attr_valid` with `attr_pair` = {0x5C value, 0x58 value}, where the written dword replaces its half. The write completes, and the register updates, in the cycle `attr_ack` is high.
- R12: `smm_flag` goes to 1 after an accepted 0x70 write whose upper half has any bit of 0x8740 set. It stays 1 until reset, and a locked write does not set it.
- R13: `rsp_valid` is high exactly in the cycle after each accepted request (`req_valid` and `req_ready` both high) and low otherwise. Write responses carry zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken this cycle when high |
| req_write | input | 1 | 1 for write, 0 for read |
| req_offset | input | ADDR_W | Byte offset, dword aligned |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | DATA_W | Read data, zero for writes and errors |
| rsp_error | output | 1 | Invalid-register error |
| hdr_sel | output | 1 | Request is for the generic header |
| hdr_write | output | 1 | Header access direction |
| hdr_offset | output | ADDR_W | Header byte offset |
| hdr_wdata | output | DATA_W | Header write data |
| hdr_rdata | input | DATA_W | Header read data, same cycle |
| hdr_err | input | 1 | Header error, same cycle |
| attr_valid | output | 1 | New attribute pair offered |
| attr_pair | output | 2*DATA_W | {attribute 2, attribute 1} after the write |
| attr_ack | input | 1 | Decoder took the pair |
| smm_flag | output | 1 | Sticky unsupported-bit attempt flag |

## Verification
Directed sequences first read every stored dword straight after reset. They then drive the system-management word through an ordered set of patterns: all zero, kept bits only, bits that must be stripped, then the lock bit, then writes that follow the lock. This separates the mask chain, the flag trigger and the lock gate from one another. Random traffic then mixes reads and writes across header, stored, constant, silent and unmapped offsets, with decoder acknowledge delays of zero to three cycles. Comparing each response against a bench model shows whether a write reached the wrong slot, an ignored write leaked into state, or an attribute pair lost its unchanged half.

// File: rtl/hbcfg_pkg.sv
package hbcfg_pkg;

   typedef enum logic [3:0] {
      K_BAD      = 4'd0,
      K_STATCMD  = 4'd1,
      K_HDR      = 4'd2,
      K_STORE    = 4'd3,
      K_ATTR_LO  = 4'd4,
      K_ATTR_HI  = 4'd5,
      K_SMM      = 4'd6,
      K_CONST_RO = 4'd7,
      K_CONST_WI = 4'd8,
      K_ZERO     = 4'd9
   } kind_e;

   localparam int NUM_STORE   = 4;
   localparam int STORE_IDX_W = $clog2(NUM_STORE);
   localparam int NUM_SILENT  = 6;

   localparam logic [5:0] IX_STATCMD = 6'h01;
   localparam logic [5:0] IX_HDR_END = 6'h10;
   localparam logic [5:0] IX_ATTR_LO = 6'h16;
   localparam logic [5:0] IX_ATTR_HI = 6'h17;
   localparam logic [5:0] IX_SMM     = 6'h1C;
   localparam logic [5:0] IX_PAGING  = 6'h1E;
   localparam logic [5:0] IX_MFG     = 6'h3E;

   localparam logic [31:0] STATCMD_VAL = 32'h0200_0006;
   localparam logic [31:0] PAGING_VAL  = 32'h380A_0000;
   localparam logic [31:0] MFG_VAL     = 32'h0000_0F20;

   localparam logic [31:0] ATTR_LO_RST = 32'h0000_0003;
   localparam logic [31:0] ATTR_HI_RST = 32'h0000_0000;

   localparam logic [15:0] SMM_RST    = 16'h3802;
   localparam logic [15:0] SMM_KEEP   = 16'hC77C;
   localparam logic [15:0] SMM_FORCE  = 16'h3802;
   localparam logic [15:0] SMM_UNSUP  = 16'h8700;
   localparam logic [15:0] SMM_NOSET  = 16'h4000;
   localparam logic [15:0] SMM_NORAM  = 16'h0040;
   localparam int          SMM_LOCK_B = 4;

   typedef struct packed {
      kind_e                  kind;
      logic [STORE_IDX_W-1:0] sidx;
      logic [31:0]            cval;
   } dec_t;

   // dword index of each plain storage slot
   function automatic logic [5:0] store_ix(input int i);
      case (i)
         0:       return 6'h18;
         1:       return 6'h19;
         2:       return 6'h34;
         default: return 6'h35;
      endcase
   endfunction

   function automatic logic [31:0] store_rst(input int i);
      case (i)
         0:       return 32'h0202_0202;
         1:       return 32'h0000_0002;
         default: return 32'h0000_0000;
      endcase
   endfunction

   // dword index of each read-as-zero, write-ignored slot
   function automatic logic [5:0] silent_ix(input int i);
      case (i)
         0:       return 6'h14;
         1:       return 6'h15;
         2:       return 6'h1A;
         3:       return 6'h1D;
         4:       return 6'h3C;
         default: return 6'h3D;
      endcase
   endfunction

endpackage

// File: rtl/hbcfg_decode.sv
module hbcfg_decode
   import hbcfg_pkg::*;
#(
   parameter int ADDR_W = 8,
   localparam int IX_W  = ADDR_W - 2
) (
   input  logic [IX_W-1:0] dw_ix,
   input  logic            is_write,
   output dec_t            dec
);

   logic [5:0] lo_ix;
   logic       hi_nz;

   assign lo_ix = dw_ix[5:0];

   if (ADDR_W > 8) begin : g_wide
      assign hi_nz = |dw_ix[IX_W-1:6];
   end else begin : g_narrow
      assign hi_nz = 1'b0;
   end

   logic              store_hit;
   logic [STORE_IDX_W-1:0] store_sel;
   logic              silent_hit;

   always_comb begin
      store_hit = 1'b0;
      store_sel = '0;
      for (int i = 0; i < NUM_STORE; i++) begin
         if (lo_ix == store_ix(i)) begin
            store_hit = 1'b1;
            store_sel = STORE_IDX_W'(i);
         end
      end
   end

   always_comb begin
      silent_hit = 1'b0;
      for (int i = 0; i < NUM_SILENT; i++) begin
         if (lo_ix == silent_ix(i)) silent_hit = 1'b1;
      end
   end

   always_comb begin
      dec      = '0;
      dec.kind = K_BAD;
      if (hi_nz) begin
         dec.kind = K_BAD;
      end else if (lo_ix == IX_STATCMD && !is_write) begin
         dec.kind = K_STATCMD;
         dec.cval = STATCMD_VAL;
      end else if (lo_ix < IX_HDR_END) begin
         dec.kind = K_HDR;
      end else if (lo_ix == IX_ATTR_LO) begin
         dec.kind = K_ATTR_LO;
      end else if (lo_ix == IX_ATTR_HI) begin
         dec.kind = K_ATTR_HI;
      end else if (lo_ix == IX_SMM) begin
         dec.kind = K_SMM;
      end else if (lo_ix == IX_PAGING) begin
         dec.kind = K_CONST_WI;
         dec.cval = PAGING_VAL;
      end else if (lo_ix == IX_MFG) begin
         dec.kind = K_CONST_RO;
         dec.cval = MFG_VAL;
      end else if (silent_hit) begin
         dec.kind = K_ZERO;
      end else if (store_hit) begin
         dec.kind = K_STORE;
         dec.sidx = store_sel;
      end
   end

endmodule

// File: rtl/hbcfg_store_bank.sv
module hbcfg_store_bank
   import hbcfg_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int NUM    = NUM_STORE,
   localparam int SEL_W = (NUM > 1) ? $clog2(NUM) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  sel,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] slot_q [NUM];

   for (genvar g = 0; g < NUM; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            slot_q[g] <= DATA_W'(store_rst(g));
         end else if (wr_en && sel == SEL_W'(g)) begin
            slot_q[g] <= wdata;
         end
      end
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM; i++) begin
         if (sel == SEL_W'(i)) rdata = slot_q[i];
      end
   end

endmodule

// File: rtl/hbcfg_smm_word.sv
module hbcfg_smm_word
   import hbcfg_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [15:0] wr_word,
   output logic [15:0] word_q,
   output logic [31:0] rd_view,
   output logic        flag_q
);

   logic [15:0] s_unsup, s_keep, s_force, s_noset, s_clean;
   logic        take;
   logic        tried_bad;

   // mask chain, applied in fixed order
   always_comb begin
      s_unsup = wr_word & ~SMM_UNSUP;
      s_keep  = s_unsup & SMM_KEEP;
      s_force = s_keep | SMM_FORCE;
      s_noset = s_force & ~SMM_NOSET;
      s_clean = s_noset & ~SMM_NORAM;
   end

   assign take      = wr_en && !word_q[SMM_LOCK_B];
   assign tried_bad = |(wr_word & (SMM_UNSUP | SMM_NORAM));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q <= SMM_RST;
         flag_q <= 1'b0;
      end else if (take) begin
         word_q <= s_clean;
         if (tried_bad) flag_q <= 1'b1;
      end
   end

   assign rd_view = {(word_q & SMM_KEEP) | SMM_FORCE, 16'h0000};

endmodule

// File: rtl/hbcfg_attr_port.sv
module hbcfg_attr_port
   import hbcfg_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter bit ACK_BYPASS = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                hit,
   input  logic                sel_hi,
   input  logic [DATA_W-1:0]   wdata,
   input  logic                ack,
   output logic [DATA_W-1:0]   lo_q,
   output logic [DATA_W-1:0]   hi_q,
   output logic                dec_valid,
   output logic [2*DATA_W-1:0] dec_pair,
   output logic                stall
);

   logic update;

   assign dec_pair  = sel_hi ? {wdata, lo_q} : {hi_q, wdata};
   assign dec_valid = hit;

   if (ACK_BYPASS) begin : g_fire
      assign stall  = 1'b0;
      assign update = hit;
   end else begin : g_hold
      assign stall  = hit && !ack;
      assign update = hit && ack;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q <= DATA_W'(ATTR_LO_RST);
         hi_q <= DATA_W'(ATTR_HI_RST);
      end else if (update) begin
         if (sel_hi) hi_q <= wdata;
         else        lo_q <= wdata;
      end
   end

endmodule

// File: rtl/hbcfg_regbank.sv
module hbcfg_regbank
   import hbcfg_pkg::*;
#(
   parameter int ADDR_W          = 8,
   parameter int DATA_W          = 32,
   parameter bit ATTR_ACK_BYPASS = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic                req_write,
   input  logic [ADDR_W-1:0]   req_offset,
   input  logic [DATA_W-1:0]   req_wdata,
   output logic                rsp_valid,
   output logic [DATA_W-1:0]   rsp_rdata,
   output logic                rsp_error,
   output logic                hdr_sel,
   output logic                hdr_write,
   output logic [ADDR_W-1:0]   hdr_offset,
   output logic [DATA_W-1:0]   hdr_wdata,
   input  logic [DATA_W-1:0]   hdr_rdata,
   input  logic                hdr_err,
   output logic                attr_valid,
   output logic [2*DATA_W-1:0] attr_pair,
   input  logic                attr_ack,
   output logic                smm_flag
);

   localparam int IX_W = ADDR_W - 2;

   if (DATA_W != 32) begin : g_bad_dw
      $error("hbcfg_regbank: DATA_W must be 32");
   end
   if (ADDR_W < 8) begin : g_bad_aw
      $error("hbcfg_regbank: ADDR_W must be at least 8");
   end

   dec_t        dec;
   logic        accept;
   logic        attr_stall;
   logic        attr_hit;
   logic [31:0] store_rd;
   logic [31:0] smm_view;
   logic [15:0] smm_word_q;
   logic [DATA_W-1:0] attr_lo_q, attr_hi_q;

   hbcfg_decode #(.ADDR_W(ADDR_W)) u_dec (
      .dw_ix    (req_offset[ADDR_W-1:2]),
      .is_write (req_write),
      .dec      (dec)
   );

   assign req_ready = !attr_stall;
   assign accept    = req_valid && req_ready;

   assign hdr_sel    = req_valid && (dec.kind == K_HDR);
   assign hdr_write  = req_write;
   assign hdr_offset = req_offset;
   assign hdr_wdata  = req_wdata;

   hbcfg_store_bank #(.DATA_W(32), .NUM(NUM_STORE)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (accept && req_write && dec.kind == K_STORE),
      .sel   (dec.sidx),
      .wdata (req_wdata[31:0]),
      .rdata (store_rd)
   );

   hbcfg_smm_word u_smm (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (accept && req_write && dec.kind == K_SMM),
      .wr_word (req_wdata[31:16]),
      .word_q  (smm_word_q),
      .rd_view (smm_view),
      .flag_q  (smm_flag)
   );

   assign attr_hit = req_valid && req_write &&
                     (dec.kind == K_ATTR_LO || dec.kind == K_ATTR_HI);

   hbcfg_attr_port #(.DATA_W(DATA_W), .ACK_BYPASS(ATTR_ACK_BYPASS)) u_attr (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit       (attr_hit),
      .sel_hi    (dec.kind == K_ATTR_HI),
      .wdata     (req_wdata),
      .ack       (attr_ack),
      .lo_q      (attr_lo_q),
      .hi_q      (attr_hi_q),
      .dec_valid (attr_valid),
      .dec_pair  (attr_pair),
      .stall     (attr_stall)
   );

   logic [DATA_W-1:0] nx_rdata;
   logic              nx_err;

   always_comb begin
      nx_rdata = '0;
      nx_err   = 1'b0;
      unique case (dec.kind)
         K_STATCMD:  nx_rdata = DATA_W'(dec.cval);
         K_HDR: begin
            nx_err = hdr_err;
            if (!req_write) nx_rdata = hdr_rdata;
         end
         K_STORE:    if (!req_write) nx_rdata = DATA_W'(store_rd);
         K_ATTR_LO:  if (!req_write) nx_rdata = attr_lo_q;
         K_ATTR_HI:  if (!req_write) nx_rdata = attr_hi_q;
         K_SMM:      if (!req_write) nx_rdata = DATA_W'(smm_view);
         K_CONST_WI: if (!req_write) nx_rdata = DATA_W'(dec.cval);
         K_CONST_RO: begin
            if (req_write) nx_err   = 1'b1;
            else           nx_rdata = DATA_W'(dec.cval);
         end
         K_ZERO:     nx_rdata = '0;
         default:    nx_err   = 1'b1;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
         rsp_error <= 1'b0;
      end else begin
         rsp_valid <= accept;
         if (accept) begin
            rsp_rdata <= nx_rdata;
            rsp_error <= nx_err;
         end
      end
   end

endmodule

// File: rtl/hbcfg_regbank_chk.sv
module hbcfg_regbank_chk #(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_offset,
   input logic              attr_valid,
   input logic              attr_ack,
   input logic              rsp_valid,
   input logic              hdr_sel,
   input logic              smm_flag,
   input logic [15:0]       smm_word
);

   a_r13_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> rsp_valid);

   a_r13_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_ready) |=> !rsp_valid);

   a_r2_hdr_low_only: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_sel |-> (req_valid && req_offset < ADDR_W'(8'h40)));

   a_r11_hold_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (attr_valid && !attr_ack) |-> !req_ready);

   a_r11_offer_write: assert property (@(posedge clk) disable iff (!rst_n)
      attr_valid |-> (req_valid && req_write));

   a_r6_word_shape: assert property (@(posedge clk) disable iff (!rst_n)
      ((smm_word & 16'h3802) == 16'h3802) && ((smm_word & 16'hC7C1) == 16'h0000));

   a_r7_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
      smm_word[4] |=> $stable(smm_word));

   a_r12_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      smm_flag |=> smm_flag);

endmodule

bind hbcfg_regbank hbcfg_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_write  (req_write),
   .req_offset (req_offset),
   .attr_valid (attr_valid),
   .attr_ack   (attr_ack),
   .rsp_valid  (rsp_valid),
   .hdr_sel    (hdr_sel),
   .smm_flag   (smm_flag),
   .smm_word   (smm_word_q)
);

// File: tb/tb_hbcfg_regbank.sv
`timescale 1ns/1ps
module tb_hbcfg_regbank;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_ready, req_write;
   logic [7:0]  req_offset;
   logic [31:0] req_wdata;
   logic        rsp_valid, rsp_error;
   logic [31:0] rsp_rdata;
   logic        hdr_sel, hdr_write;
   logic [7:0]  hdr_offset;
   logic [31:0] hdr_wdata, hdr_rdata;
   logic        hdr_err;
   logic        attr_valid, attr_ack;
   logic [63:0] attr_pair;
   logic        smm_flag;

   always #4 clk = ~clk;

   // header stub
   assign hdr_rdata = 32'hC0DE_0000 | {24'h0, hdr_offset};
   assign hdr_err   = (hdr_offset == 8'h3C);

   hbcfg_regbank dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_offset(req_offset), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_error(rsp_error),
      .hdr_sel(hdr_sel), .hdr_write(hdr_write), .hdr_offset(hdr_offset),
      .hdr_wdata(hdr_wdata), .hdr_rdata(hdr_rdata), .hdr_err(hdr_err),
      .attr_valid(attr_valid), .attr_pair(attr_pair), .attr_ack(attr_ack),
      .smm_flag(smm_flag)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   logic [31:0] m_store [4];
   logic [31:0] m_lo, m_hi;
   logic [15:0] m_smm;
   bit          m_flag;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic int slot_of(input logic [7:0] off);
      case (off)
         8'h60: return 0;
         8'h64: return 1;
         8'hD0: return 2;
         8'hD4: return 3;
         default: return -1;
      endcase
   endfunction

   function automatic bit is_silent(input logic [7:0] off);
      return off == 8'h50 || off == 8'h54 || off == 8'h68 ||
             off == 8'h74 || off == 8'hF0 || off == 8'hF4;
   endfunction

   function automatic string tag_of(input bit wr, input logic [7:0] off);
      if (off == 8'h04 && !wr) return "R1";
      if (off < 8'h40) return "R2";
      if (off == 8'h58 || off == 8'h5C) return "R11";
      if (off == 8'h70) return wr ? "R6" : "R5";
      if (slot_of(off) >= 0) return "R4";
      if (off == 8'h78 || off == 8'hF8) return "R8";
      if (is_silent(off)) return "R9";
      return "R10";
   endfunction

   task automatic model_reset();
      m_store[0] = 32'h0202_0202;
      m_store[1] = 32'h0000_0002;
      m_store[2] = 32'h0;
      m_store[3] = 32'h0;
      m_lo   = 32'h3;
      m_hi   = 32'h0;
      m_smm  = 16'h3802;
      m_flag = 0;
   endtask

   task automatic exp_resp(input bit wr, input logic [7:0] off, output logic err, output logic [31:0] d);
      err = 0;
      d   = 32'h0;
      if (off == 8'h04 && !wr) d = 32'h0200_0006;
      else if (off < 8'h40) begin
         err = (off == 8'h3C);
         if (!wr) d = 32'hC0DE_0000 | {24'h0, off};
      end
      else if (off == 8'h58) begin if (!wr) d = m_lo; end
      else if (off == 8'h5C) begin if (!wr) d = m_hi; end
      else if (off == 8'h70) begin if (!wr) d = {(m_smm & 16'hC77C) | 16'h3802, 16'h0}; end
      else if (slot_of(off) >= 0) begin if (!wr) d = m_store[slot_of(off)]; end
      else if (off == 8'h78) begin if (!wr) d = 32'h380A_0000; end
      else if (off == 8'hF8) begin if (wr) err = 1; else d = 32'h0000_0F20; end
      else if (is_silent(off)) d = 32'h0;
      else err = 1;
   endtask

   task automatic model_apply(input bit wr, input logic [7:0] off, input logic [31:0] wd);
      logic [15:0] nw;
      if (!wr) return;
      if (off == 8'h58) m_lo = wd;
      else if (off == 8'h5C) m_hi = wd;
      else if (slot_of(off) >= 0) m_store[slot_of(off)] = wd;
      else if (off == 8'h70 && !m_smm[4]) begin
         nw = wd[31:16];
         if ((nw & 16'h8740) != 0) m_flag = 1;
         m_smm = (nw & 16'h003C) | 16'h3802;
      end
   endtask

   task automatic do_req(input bit wr, input logic [7:0] off, input logic [31:0] wd, input string tg);
      logic        ee;
      logic [31:0] ed;
      bit          attr;
      string       t;
      t = (tg == "") ? tag_of(wr, off) : tg;
      exp_resp(wr, off, ee, ed);
      attr = wr && (off == 8'h58 || off == 8'h5C);
      @(negedge clk);
      req_valid = 1; req_write = wr; req_offset = off; req_wdata = wd;
      #1;
      if (off < 8'h40 && !(off == 8'h04 && !wr))
         chk(hdr_sel === 1'b1 && hdr_write === wr, "R2 header select", {hdr_sel, hdr_write}, {1'b1, wr});
      else
         chk(hdr_sel === 1'b0, "R1/R2 no header select", hdr_sel, 0);
      if (attr) begin
         chk(req_ready === 1'b0 && attr_valid === 1'b1, "R11 stall and offer", {req_ready, attr_valid}, 2'b01);
         chk(attr_pair === ((off == 8'h5C) ? {wd, m_lo} : {m_hi, wd}), "R11 pair",
             attr_pair, (off == 8'h5C) ? {wd, m_lo} : {m_hi, wd});
         repeat ($urandom_range(0, 3)) @(negedge clk);
         attr_ack = 1;
      end else begin
         chk(req_ready === 1'b1 && attr_valid === 1'b0, "R11 no offer", {req_ready, attr_valid}, 2'b10);
      end
      @(posedge clk);
      @(negedge clk);
      req_valid = 0; attr_ack = 0;
      chk(rsp_valid === 1'b1, {"R13 response ", t}, rsp_valid, 1);
      chk(rsp_error === ee, {t, " error"}, rsp_error, ee);
      chk(rsp_rdata === ed, {t, " data"}, rsp_rdata, ed);
      model_apply(wr, off, wd);
      chk(smm_flag === m_flag, "R12 flag", smm_flag, m_flag);
   endtask

   task automatic do_reset();
      rst_n = 0; req_valid = 0; req_write = 0; req_offset = 0; req_wdata = 0; attr_ack = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      model_reset();
      #1;
      chk(rsp_valid === 1'b0 && smm_flag === 1'b0 && req_ready === 1'b1,
          "R3 reset outputs", {rsp_valid, smm_flag, req_ready}, 3'b001);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   localparam logic [7:0] OFFS [24] = '{
      8'h00, 8'h04, 8'h08, 8'h3C, 8'h50, 8'h54, 8'h58, 8'h5C,
      8'h60, 8'h64, 8'h68, 8'h6C, 8'h70, 8'h74, 8'h78, 8'h7C,
      8'hCC, 8'hD0, 8'hD4, 8'hF0, 8'hF4, 8'hF8, 8'h44, 8'hFC};

   initial begin
      void'($urandom(32'd4242));
      do_reset();

      // R3 reset values
      do_req(0, 8'h60, 0, "R3");
      do_req(0, 8'h64, 0, "R3");
      do_req(0, 8'hD0, 0, "R3");
      do_req(0, 8'hD4, 0, "R3");
      do_req(0, 8'h58, 0, "R3");
      do_req(0, 8'h5C, 0, "R3");
      do_req(0, 8'h70, 0, "R3");

      // R13 idle cycle gives no response
      @(negedge clk);
      chk(rsp_valid === 1'b0, "R13 idle", rsp_valid, 0);

      // R1 / R2
      do_req(0, 8'h04, 0, "");
      do_req(1, 8'h04, 32'h1234_5678, "R1 write to header");
      do_req(0, 8'h10, 0, "");
      do_req(0, 8'h3C, 0, "");

      // R4
      do_req(1, 8'h60, 32'hDEAD_BEEF, "");
      do_req(0, 8'h60, 0, "");
      do_req(1, 8'hD4, 32'hA5A5_0001, "");
      do_req(0, 8'hD4, 0, "");

      // R8 / R9 / R10
      do_req(1, 8'h78, 32'hFFFF_FFFF, "");
      do_req(0, 8'h78, 0, "");
      do_req(1, 8'hF8, 32'h1, "");
      do_req(0, 8'hF8, 0, "");
      do_req(1, 8'h68, 32'hFFFF_FFFF, "");
      do_req(0, 8'h68, 0, "");
      do_req(0, 8'h7C, 0, "");
      do_req(1, 8'hCC, 32'h5, "");

      // R11
      do_req(1, 8'h58, 32'h3333_0000, "");
      do_req(1, 8'h5C, 32'h0000_1111, "");
      do_req(0, 8'h58, 0, "");
      do_req(0, 8'h5C, 0, "");

      // R6 / R12 / R7 system-management sequence
      do_req(1, 8'h70, 32'h0000_FFFF, "R6 zero upper");
      do_req(0, 8'h70, 0, "R6 readback");
      do_req(1, 8'h70, 32'h002C_0000, "R6 kept bits");
      do_req(0, 8'h70, 0, "R6 readback");
      do_req(1, 8'h70, 32'h8748_0000, "R12 stripped bits");
      do_req(0, 8'h70, 0, "R6 readback");
      do_req(1, 8'h70, 32'h0010_0000, "R7 lock");
      do_req(1, 8'h70, 32'h0000_0000, "R7 locked write");
      do_req(0, 8'h70, 0, "R7 frozen");

      // fresh reset, then random traffic
      do_reset();
      do_req(1, 8'h70, 32'h0008_0000, "R12 clean write");
      do_req(1, 8'h70, 32'h0010_0000, "R7 lock");
      do_req(1, 8'h70, 32'hFFFF_0000, "R12 locked no flag");
      do_req(0, 8'h70, 0, "R7 frozen");
      do_reset();
      for (int k = 0; k < 400; k++) begin
         logic [7:0] o;
         o = OFFS[$urandom_range(0, 23)];
         do_req(1'($urandom_range(0, 1)), o, $urandom, "");
      end

      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule